// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit bidirectional buses, called A and B. Each direction has its own bank of flip-flops on its own clock. The A-to-B bank samples bus A, and the B-to-A bank samples bus B. In front of each output driver, a per-direction source select chooses one of two values: the live value on the opposite bus, or the value held in that direction's bank. A per-direction output enable decides whether the block drives the destination bus or leaves it high-impedance, so that the bus acts as an input.

Because capture and driving are separate, a bus value can be passed straight through, stored with the outputs off and replayed later, or sent back in the opposite direction. If both directions are enabled and both select live data, each bus would be driven from the other, which forms a combinational loop. In that case the block releases both buses. One direction in stored mode, or one direction disabled, allows normal operation.

Top module: `regbus_xcvr`

## Requirements
- R1: On a rising edge of `clk_ab` the A-to-B bank loads the value on bus A. On a rising edge of `clk_ba` the B-to-A bank loads the value on bus B.
- R2: Reset is synchronous and active high. While `rst` is high, a rising edge of `clk_ab` clears the A-to-B bank to 0 and a rising edge of `clk_ba` clears the B-to-A bank to 0. Each bank is cleared only by its own clock.
- R3: When `oe_ab` is 1 the block drives bus B. When `oe_ab` is 0 bus B is high-impedance, and a value driven onto it from outside appears unchanged.
- R4: When `oe_ba_n` is 0 the block drives bus A. When `oe_ba_n` is 1 bus A is high-impedance, and a value driven onto it from outside appears unchanged.
- R5: `sel_ab` = 0 drives bus B with the live value of bus A in the same cycle. `sel_ab` = 1 drives bus B with the A-to-B bank.
- R6: `sel_ba` = 0 drives bus A with the live value of bus B in the same cycle. `sel_ba` = 1 drives bus A with the B-to-A bank.
- R7: A bank loads on its clock edge even while its output is disabled. The stored value is driven later when the output is enabled with stored mode selected.
- R8: When `oe_ab` = 1, `oe_ba_n` = 0, `sel_ab` = 0 and `sel_ba` = 0 all hold together, the block releases both buses to high-impedance.
- R9: With both directions enabled and at least one in stored mode, both buses are driven without a loop. A stored direction drives its bank. A live direction forwards the value the block itself places on the source bus.
- R10: A bank holds its value while its clock does not rise. This includes every edge of the other direction's clock and any change on the source bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Capture clock of the A-to-B bank (rising edge) |
| clk_ba | input | 1 | Capture clock of the B-to-A bank (rising edge) |
| rst | input | 1 | Synchronous active-high reset, taken by each bank on its own clock |
| sel_ab | input | 1 | Source for bus B: 0 live bus A, 1 A-to-B bank |
| sel_ba | input | 1 | Source for bus A: 0 live bus B, 1 B-to-A bank |
| oe_ab | input | 1 | Active-high enable of the driver onto bus B |
| oe_ba_n | input | 1 | Active-low enable of the driver onto bus A |
| bus_a | inout | 8 | Bus A: input to the A-to-B bank, output of the B-to-A path |
| bus_b | inout | 8 | Bus B: input to the B-to-A bank, output of the A-to-B path |

## Verification
The released-bus cases are checked by driving a bus from outside with a value whose wired combination with the block's would-be value differs. A block that wrongly drives the bus therefore shows a corrupted value, and the contention monitor reports it. The both-live case checks that the block releases both buses. A design that still drove them would form a loop or fight the external drivers. The enable polarities are tested separately, so swapping the active level of either enable shows up. Single-clock pulses and one-sided reset catch banks that share a clock or a reset path. The replay-after-disabled-capture sequence catches a capture gated by the output enable.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;

    localparam int unsigned XCVR_W = 8;

    // Source of the value placed on a destination bus
    typedef enum logic {
        SRC_LIVE = 1'b0,
        SRC_HELD = 1'b1
    } src_sel_e;

    // Resolved control of one direction after the loop guard
    typedef struct packed {
        logic     drive;
        src_sel_e src;
    } dir_ctl_t;

    // True when both directions would drive live data into each other
    function automatic logic loop_risk(input logic en_ab, input logic en_ba,
                                       input src_sel_e s_ab, input src_sel_e s_ba);
        return en_ab && en_ba && (s_ab == SRC_LIVE) && (s_ba == SRC_LIVE);
    endfunction

endpackage

// File: rtl/xcvr_bank.sv
module xcvr_bank #(
    parameter int unsigned W = regbus_xcvr_pkg::XCVR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
    import regbus_xcvr_pkg::*;
(
    input  logic     oe_ab,
    input  logic     oe_ba_n,
    input  logic     sel_ab,
    input  logic     sel_ba,
    output dir_ctl_t ctl_ab,
    output dir_ctl_t ctl_ba,
    output logic     guard
);
    logic     want_ab;
    logic     want_ba;
    src_sel_e s_ab;
    src_sel_e s_ba;

    always_comb begin
        want_ab = oe_ab;
        want_ba = ~oe_ba_n;
        s_ab    = src_sel_e'(sel_ab);
        s_ba    = src_sel_e'(sel_ba);
        guard   = loop_risk(want_ab, want_ba, s_ab, s_ba);
        ctl_ab.drive = want_ab & ~guard;
        ctl_ab.src   = s_ab;
        ctl_ba.drive = want_ba & ~guard;
        ctl_ba.src   = s_ba;
    end
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
    import regbus_xcvr_pkg::*;
#(
    parameter int unsigned W = XCVR_W
) (
    input  dir_ctl_t     ctl,
    input  dir_ctl_t     ctl_rev,
    input  logic [W-1:0] held_q,
    input  logic [W-1:0] rev_held_q,
    input  logic [W-1:0] src_bus,
    output logic [W-1:0] drv_val
);
    logic [W-1:0] live_val;

    // If the block drives the source bus itself, the guard ensures the
    // reverse path is in stored mode, so the bus carries rev_held_q.
    always_comb begin
        live_val = ctl_rev.drive ? rev_held_q : src_bus;
        drv_val  = (ctl.src == SRC_HELD) ? held_q : live_val;
    end
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
    import regbus_xcvr_pkg::*;
(
    input  logic              clk_ab,
    input  logic              clk_ba,
    input  logic              rst,
    input  logic              sel_ab,
    input  logic              sel_ba,
    input  logic              oe_ab,
    input  logic              oe_ba_n,
    inout  wire  [XCVR_W-1:0] bus_a,
    inout  wire  [XCVR_W-1:0] bus_b
);
    localparam int unsigned W = XCVR_W;

    dir_ctl_t     ctl_ab;
    dir_ctl_t     ctl_ba;
    logic         guard;
    logic [W-1:0] reg_ab_q;
    logic [W-1:0] reg_ba_q;
    logic [W-1:0] drv_b;
    logic [W-1:0] drv_a;

    xcvr_drive_ctl u_ctl (
        .oe_ab   (oe_ab),
        .oe_ba_n (oe_ba_n),
        .sel_ab  (sel_ab),
        .sel_ba  (sel_ba),
        .ctl_ab  (ctl_ab),
        .ctl_ba  (ctl_ba),
        .guard   (guard)
    );

    xcvr_bank #(.W(W)) u_bank_ab (
        .clk (clk_ab),
        .rst (rst),
        .d   (bus_a),
        .q   (reg_ab_q)
    );

    xcvr_bank #(.W(W)) u_bank_ba (
        .clk (clk_ba),
        .rst (rst),
        .d   (bus_b),
        .q   (reg_ba_q)
    );

    xcvr_path #(.W(W)) u_path_ab (
        .ctl        (ctl_ab),
        .ctl_rev    (ctl_ba),
        .held_q     (reg_ab_q),
        .rev_held_q (reg_ba_q),
        .src_bus    (bus_a),
        .drv_val    (drv_b)
    );

    xcvr_path #(.W(W)) u_path_ba (
        .ctl        (ctl_ba),
        .ctl_rev    (ctl_ab),
        .held_q     (reg_ba_q),
        .rev_held_q (reg_ab_q),
        .src_bus    (bus_b),
        .drv_val    (drv_a)
    );

    assign bus_b = ctl_ab.drive ? drv_b : {W{1'bz}};
    assign bus_a = ctl_ba.drive ? drv_a : {W{1'bz}};

    // R1: each bank follows its source bus one edge later
    a_r1_cap_ab: assert property (@(posedge clk_ab) disable iff (rst)
        1'b1 |=> reg_ab_q == $past(bus_a));
    a_r1_cap_ba: assert property (@(posedge clk_ba) disable iff (rst)
        1'b1 |=> reg_ba_q == $past(bus_b));

    // R8: the both-live request leaves neither driver on
    a_r8_loop_guard: assert property (@(posedge clk_ab) disable iff (rst)
        (oe_ab && !oe_ba_n && !sel_ab && !sel_ba) |-> (!ctl_ab.drive && !ctl_ba.drive));

    // R5: stored mode on B presents the A-to-B bank
    a_r5_held_b: assert property (@(posedge clk_ab) disable iff (rst)
        (oe_ab && sel_ab) |-> drv_b == reg_ab_q);

    // R6: stored mode on A presents the B-to-A bank
    a_r6_held_a: assert property (@(posedge clk_ba) disable iff (rst)
        (!oe_ba_n && sel_ba) |-> drv_a == reg_ba_q);

endmodule

// File: tb/regbus_xcvr_bench.sv
module regbus_xcvr_bench;

    typedef struct packed {
        logic [3:0] req;
        logic       oe_ab;
        logic       oe_ba_n;
        logic       sel_ab;
        logic       sel_ba;
        logic       xa_en;
        logic [7:0] xa;
        logic       xb_en;
        logic [7:0] xb;
        logic [7:0] ea;
        logic [7:0] eb;
    } vec_t;

    // Banks preloaded with A-to-B = 3C and B-to-A = C3 before this table
    localparam vec_t VEC [10] = '{
        '{4'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h5A, 1'b0, 8'h00, 8'h5A, 8'h5A}, // R5 live
        '{4'd5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h5A, 1'b0, 8'h00, 8'h5A, 8'h3C}, // R5 held
        '{4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h81, 1'b1, 8'h42, 8'h81, 8'h42}, // R3 off
        '{4'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h66, 8'h66, 8'h66}, // R6 live
        '{4'd6, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 8'h66, 8'hC3, 8'h66}, // R6 held
        '{4'd4, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h18, 1'b1, 8'h24, 8'h18, 8'h24}, // R4 off
        '{4'd8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h11, 1'b1, 8'h22, 8'h11, 8'h22}, // R8 guard
        '{4'd9, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h3C, 8'h3C}, // R9
        '{4'd9, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 8'hC3, 8'hC3}, // R9
        '{4'd9, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 8'hC3, 8'h3C}  // R9
    };

    logic clk = 1'b0;
    logic clk_ab = 1'b0;
    logic clk_ba = 1'b0;
    logic rst = 1'b1;
    logic sel_ab = 1'b0;
    logic sel_ba = 1'b0;
    logic oe_ab = 1'b0;
    logic oe_ba_n = 1'b1;
    logic       xa_en = 1'b0;
    logic [7:0] xa = 8'h00;
    logic       xb_en = 1'b0;
    logic [7:0] xb = 8'h00;
    wire  [7:0] bus_a;
    wire  [7:0] bus_b;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    assign bus_a = xa_en ? xa : 8'bz;
    assign bus_b = xb_en ? xb : 8'bz;

    always #2 clk = ~clk;

    regbus_xcvr u_regbus_xcvr (
        .clk_ab  (clk_ab),
        .clk_ba  (clk_ba),
        .rst     (rst),
        .sel_ab  (sel_ab),
        .sel_ba  (sel_ba),
        .oe_ab   (oe_ab),
        .oe_ba_n (oe_ba_n),
        .bus_a   (bus_a),
        .bus_b   (bus_b)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic ab, input logic ba);
        @(posedge clk);
        clk_ab = ab;
        clk_ba = ba;
        @(posedge clk);
        clk_ab = 1'b0;
        clk_ba = 1'b0;
    endtask

    task automatic drive(input logic oab, input logic oban, input logic sab, input logic sba,
                         input logic ae, input logic [7:0] av,
                         input logic be, input logic [7:0] bv);
        @(posedge clk);
        oe_ab = oab; oe_ba_n = oban; sel_ab = sab; sel_ba = sba;
        xa_en = ae; xa = av; xb_en = be; xb = bv;
        @(negedge clk);
    endtask

    // Contention monitor for R3 and R4: an externally driven bus must carry the external value
    always @(negedge clk) begin
        if (!done && !rst) begin
            if (xa_en && bus_a !== xa) begin
                total++; fails++;
                $display("FAIL R4 contention on bus A: actual %02h expected %02h", bus_a, xa);
            end
            if (xb_en && bus_b !== xb) begin
                total++; fails++;
                $display("FAIL R3 contention on bus B: actual %02h expected %02h", bus_b, xb);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R2: reset clears both banks
        pulse(1'b1, 1'b1);
        pulse(1'b1, 1'b1);
        @(posedge clk); rst = 1'b0;
        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        check("R2 reset A-to-B bank", bus_b, 8'h00);
        check("R2 reset B-to-A bank", bus_a, 8'h00);

        // R1 / R10: load only the A-to-B bank
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h3C, 1'b1, 8'h99);
        pulse(1'b1, 1'b0);
        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        check("R1 A-to-B bank load", bus_b, 8'h3C);
        check("R10 B-to-A bank untouched by clk_ab", bus_a, 8'h00);

        // R1: load the B-to-A bank
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'hC3);
        pulse(1'b0, 1'b1);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        check("R1 B-to-A bank load", bus_a, 8'hC3);

        // R10: source changes without a clock edge leave the bank alone
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 1'b0, 8'h00);
        repeat (3) @(negedge clk);
        check("R10 hold without clk_ab", bus_b, 8'h3C);

        // Combinational table
        for (int i = 0; i < 10; i++) begin
            drive(VEC[i].oe_ab, VEC[i].oe_ba_n, VEC[i].sel_ab, VEC[i].sel_ba,
                  VEC[i].xa_en, VEC[i].xa, VEC[i].xb_en, VEC[i].xb);
            check($sformatf("R%0d row %0d bus A", VEC[i].req, i), bus_a, VEC[i].ea);
            check($sformatf("R%0d row %0d bus B", VEC[i].req, i), bus_b, VEC[i].eb);
        end

        // R7: capture with outputs off, replay later
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h77, 1'b0, 8'h00);
        pulse(1'b1, 1'b0);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 8'h08);
        check("R7 bus B free while disabled", bus_b, 8'h08);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        check("R7 replay stored value", bus_b, 8'h77);

        // R2: reset taken by clk_ab only clears just the A-to-B bank
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        @(posedge clk); rst = 1'b1;
        pulse(1'b1, 1'b0);
        @(posedge clk); rst = 1'b0;
        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        check("R2 one-sided reset clears A-to-B", bus_b, 8'h00);
        check("R2 one-sided reset keeps B-to-A", bus_a, 8'hC3);

        finish_run();
    end

endmodule